// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Programmable Output Sense

The block collects interrupt events into a 32-bit top-level pending register and drives one interrupt line from it. Two subordinate banks feed the top level. One holds 32 endpoint event bits and the other holds DMA-completion bits. Every bank has a pending register and a mask register, and software changes pending through a write-one-to-set address and a write-one-to-clear address. The three summary bits of the top level are not stored in their own right. Each is recomputed every cycle from the unmasked pending bits of its subordinate bank. The endpoint bank folds into two of these bits: one covers its low half (transmit) and one covers its high half (receive).

A configuration register selects the sense of the output line. With the sense bit set, the line is high while any unmasked top-level bit is pending. With it clear, the line is high only while no unmasked top-level bit is pending. A settle gate holds the line low after power is applied. It opens once the power input has been high for a programmable number of clock cycles, and it closes again when power is removed. Hardware events can land in the same cycle as a clear write. When they do, they are merged with it and the hardware set wins.

The register port is a single-cycle write strobe with a shared word address. Read data is combinational from the current address. The defaults give a half-second settle delay at a 60 MHz clock.

Top module: `irq_tree_top`

## Requirements
- R1: After reset, every pending register and the configuration register read zero, every mask register reads all ones, and irq_out is low.
- R2: A write to a bank's set address ORs the write data into that bank's pending register. Reads of the source, set and clear addresses of a bank all return its pending value.
- R3: A write to a bank's clear address clears exactly the pending bits where the write data holds ones.
- R4: A write to a bank's mask address replaces its mask, and a read of the mask address returns it. A mask bit of 1 hides the matching pending bit.
- R5: Top-level bit 9 is 1 exactly when some unmasked endpoint bit in positions 15:0 is pending. Set and clear writes to top-level bits 9, 8 and 24 have no effect.
- R6: Top-level bit 8 is 1 exactly when some unmasked endpoint bit in positions 31:16 is pending.
- R7: Top-level bit 24 is 1 exactly when some unmasked DMA bit is pending.
- R8: While the gate is open, irq_out follows configuration bit 17. When bit 17 is 1, irq_out is high if any unmasked top-level bit is pending. When bit 17 is 0, irq_out is high only if none is pending. A mask or configuration write takes effect on irq_out in the cycle after the write edge.
- R9: irq_out is low while the gate is closed. The gate opens after SETTLE_CYCLES rising edges with pwr_on high, and it closes at the first rising edge with pwr_on low.
- R10: A tmr_expire pulse sets top-level bit 16 and a vbus_edge pulse sets bit 15. A high bit on ep_evt, dma_evt or top_evt at an edge sets the same bit of the endpoint, DMA or top pending register.
- R11: A hardware set that arrives in the same cycle as a clear write to the same bit leaves the bit set.
- R12: Word address map: 0–3 are the top bank (source, set, clear, mask), 4–7 the endpoint bank, 8–11 the DMA bank, and 12 the configuration register. Addresses 13–15 read zero and ignore writes. DMA values are zero-extended on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Power-present level that starts the settle gate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ep_evt | input | 32 | Endpoint event set pulses |
| dma_evt | input | DMA_W | DMA completion set pulses |
| top_evt | input | 32 | Direct top-level event set pulses |
| tmr_expire | input | 1 | Timer expiry event (top bit 16) |
| vbus_edge | input | 1 | Supply-sense change event (top bit 15) |
| irq_out | output | 1 | Interrupt line |

## Verification
The bench probes the summary bits from both sides. It unmasks and masks each endpoint half separately. A design that swapped the halves, or that read the summary from the raw pending bits instead of the unmasked ones, would report the wrong bit or keep it set after masking. It also tries to set and clear the summary bits directly, which a design that let them latch would keep.

The bench counts the settle window cycle by cycle, so a gate that opens one edge early or late, or that ignores the drop of power, shows up as a mismatch on irq_out. It runs both output senses with pending and idle states, which would catch an inverted sense. It also lines up a clear write with a timer event, and a design with the wrong merge order would lose that event.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_TOP_SRC = 4'd0,
        A_TOP_SET = 4'd1,
        A_TOP_CLR = 4'd2,
        A_TOP_MSK = 4'd3,
        A_EP_SRC  = 4'd4,
        A_EP_SET  = 4'd5,
        A_EP_CLR  = 4'd6,
        A_EP_MSK  = 4'd7,
        A_DMA_SRC = 4'd8,
        A_DMA_SET = 4'd9,
        A_DMA_CLR = 4'd10,
        A_DMA_MSK = 4'd11,
        A_CFG     = 4'd12
    } reg_addr_e;

    localparam int unsigned TX_SUM_BIT  = 9;
    localparam int unsigned RX_SUM_BIT  = 8;
    localparam int unsigned DMA_SUM_BIT = 24;
    localparam int unsigned TMR_BIT     = 16;
    localparam int unsigned VBUS_BIT    = 15;
    localparam int unsigned POL_BIT     = 17;

    typedef struct packed {
        logic set_we;
        logic clr_we;
        logic msk_we;
    } bank_we_t;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_tree_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bank_we_t     we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] frc_en,
    input  logic [W-1:0] frc_val,
    output logic [W-1:0] pend_d,
    output logic [W-1:0] msk_d,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] msk_q
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] msk;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we.set_we) st_d.pend = st_d.pend | wdata;
        if (we.clr_we) st_d.pend = st_d.pend & ~wdata;
        if (we.msk_we) st_d.msk  = wdata;
        // hardware events merge after software clear, so they win
        st_d.pend = st_d.pend | hw_set;
        st_d.pend = (st_d.pend & ~frc_en) | (frc_val & frc_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.msk  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d = st_d.pend;
    assign msk_d  = st_d.msk;
    assign pend_q = st_q.pend;
    assign msk_q  = st_q.msk;
endmodule

// File: rtl/irq_settle_gate.sv
module irq_settle_gate #(
    parameter int unsigned SETTLE_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    output logic gate_open
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_on)                st_d.cnt = '0;
        else if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_open = (st_q.cnt == CNT_MAX);
endmodule

// File: rtl/irq_regif.sv
module irq_regif
    import irq_tree_pkg::*;
(
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  top_pend,
    input  logic [REG_W-1:0]  top_msk,
    input  logic [REG_W-1:0]  ep_pend,
    input  logic [REG_W-1:0]  ep_msk,
    input  logic [REG_W-1:0]  dma_pend,
    input  logic [REG_W-1:0]  dma_msk,
    input  logic [REG_W-1:0]  cfg,
    output bank_we_t          top_we,
    output bank_we_t          ep_we,
    output bank_we_t          dma_we,
    output logic              cfg_we,
    output logic [REG_W-1:0]  bus_rdata
);
    reg_addr_e a;

    always_comb begin
        a         = reg_addr_e'(bus_addr);
        top_we    = '0;
        ep_we     = '0;
        dma_we    = '0;
        cfg_we    = 1'b0;
        bus_rdata = '0;
        case (a)
            A_TOP_SRC: bus_rdata = top_pend;
            A_TOP_SET: begin bus_rdata = top_pend; top_we.set_we = bus_wr; end
            A_TOP_CLR: begin bus_rdata = top_pend; top_we.clr_we = bus_wr; end
            A_TOP_MSK: begin bus_rdata = top_msk;  top_we.msk_we = bus_wr; end
            A_EP_SRC:  bus_rdata = ep_pend;
            A_EP_SET:  begin bus_rdata = ep_pend;  ep_we.set_we  = bus_wr; end
            A_EP_CLR:  begin bus_rdata = ep_pend;  ep_we.clr_we  = bus_wr; end
            A_EP_MSK:  begin bus_rdata = ep_msk;   ep_we.msk_we  = bus_wr; end
            A_DMA_SRC: bus_rdata = dma_pend;
            A_DMA_SET: begin bus_rdata = dma_pend; dma_we.set_we = bus_wr; end
            A_DMA_CLR: begin bus_rdata = dma_pend; dma_we.clr_we = bus_wr; end
            A_DMA_MSK: begin bus_rdata = dma_msk;  dma_we.msk_we = bus_wr; end
            A_CFG:     begin bus_rdata = cfg;      cfg_we        = bus_wr; end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_tree_top.sv
module irq_tree_top
    import irq_tree_pkg::*;
#(
    parameter int unsigned DMA_W         = 16,
    parameter int unsigned SETTLE_CYCLES = 30_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       ep_evt,
    input  logic [DMA_W-1:0]  dma_evt,
    input  logic [31:0]       top_evt,
    input  logic              tmr_expire,
    input  logic              vbus_edge,
    output logic              irq_out
);
    localparam int unsigned EP_W    = REG_W;
    localparam int unsigned EP_HALF = EP_W / 2;
    localparam logic [REG_W-1:0] SUM_MASK =
        (REG_W'(1) << TX_SUM_BIT) | (REG_W'(1) << RX_SUM_BIT) | (REG_W'(1) << DMA_SUM_BIT);

    typedef struct packed {
        logic [REG_W-1:0] cfg;
    } top_st_t;

    top_st_t st_d, st_q;

    bank_we_t top_we, ep_we, dma_we;
    logic     cfg_we, gate;

    logic [EP_W-1:0]  ep_pend_d, ep_msk_d, ep_pend_q, ep_msk_q;
    logic [DMA_W-1:0] dma_pend_d, dma_msk_d, dma_pend_q, dma_msk_q;
    logic [REG_W-1:0] top_pend_d, top_msk_d, top_pend_q, top_msk_q;
    logic [REG_W-1:0] dma_pend_rd, dma_msk_rd, top_hw, sum_val;
    logic             tx_sum, rx_sum, dma_sum, any_act;

    irq_regif u_regif (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .top_pend (top_pend_q),
        .top_msk  (top_msk_q),
        .ep_pend  (ep_pend_q),
        .ep_msk   (ep_msk_q),
        .dma_pend (dma_pend_rd),
        .dma_msk  (dma_msk_rd),
        .cfg      (st_q.cfg),
        .top_we   (top_we),
        .ep_we    (ep_we),
        .dma_we   (dma_we),
        .cfg_we   (cfg_we),
        .bus_rdata(bus_rdata)
    );

    irq_bank #(.W(EP_W)) u_ep (
        .clk(clk), .rst_n(rst_n), .we(ep_we), .wdata(bus_wdata),
        .hw_set(ep_evt), .frc_en('0), .frc_val('0),
        .pend_d(ep_pend_d), .msk_d(ep_msk_d), .pend_q(ep_pend_q), .msk_q(ep_msk_q)
    );

    irq_bank #(.W(DMA_W)) u_dma (
        .clk(clk), .rst_n(rst_n), .we(dma_we), .wdata(bus_wdata[DMA_W-1:0]),
        .hw_set(dma_evt), .frc_en('0), .frc_val('0),
        .pend_d(dma_pend_d), .msk_d(dma_msk_d), .pend_q(dma_pend_q), .msk_q(dma_msk_q)
    );

    // summaries follow the next-state of the subordinate banks so the
    // top level tracks them in the same cycle
    always_comb begin
        tx_sum  = |(ep_pend_d[EP_HALF-1:0]    & ~ep_msk_d[EP_HALF-1:0]);
        rx_sum  = |(ep_pend_d[EP_W-1:EP_HALF] & ~ep_msk_d[EP_W-1:EP_HALF]);
        dma_sum = |(dma_pend_d & ~dma_msk_d);
        sum_val = '0;
        sum_val[TX_SUM_BIT]  = tx_sum;
        sum_val[RX_SUM_BIT]  = rx_sum;
        sum_val[DMA_SUM_BIT] = dma_sum;
        top_hw  = top_evt;
        top_hw[TMR_BIT]  = top_evt[TMR_BIT]  | tmr_expire;
        top_hw[VBUS_BIT] = top_evt[VBUS_BIT] | vbus_edge;
        dma_pend_rd = '0;
        dma_msk_rd  = '0;
        dma_pend_rd[DMA_W-1:0] = dma_pend_q;
        dma_msk_rd[DMA_W-1:0]  = dma_msk_q;
    end

    irq_bank #(.W(REG_W)) u_top (
        .clk(clk), .rst_n(rst_n), .we(top_we), .wdata(bus_wdata),
        .hw_set(top_hw), .frc_en(SUM_MASK), .frc_val(sum_val),
        .pend_d(top_pend_d), .msk_d(top_msk_d), .pend_q(top_pend_q), .msk_q(top_msk_q)
    );

    irq_settle_gate #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .gate_open(gate)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        any_act = |(top_pend_q & ~top_msk_q);
        irq_out = gate & (st_q.cfg[POL_BIT] ? any_act : ~any_act);
    end
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
    import irq_tree_pkg::*;
#(
    parameter int unsigned DMA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_on,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              tmr_expire,
    input logic              irq_out,
    input logic              gate,
    input logic [31:0]       cfg,
    input logic [31:0]       top_pend,
    input logic [31:0]       top_msk,
    input logic [31:0]       ep_pend,
    input logic [31:0]       ep_msk,
    input logic [DMA_W-1:0]  dma_pend,
    input logic [DMA_W-1:0]  dma_msk
);
    localparam logic [31:0] FREE_BITS =
        ~((32'd1 << TX_SUM_BIT) | (32'd1 << RX_SUM_BIT) | (32'd1 << DMA_SUM_BIT));

    // R5
    tx_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_pend[TX_SUM_BIT] == (($countones(ep_pend[15:0] & ~ep_msk[15:0])) != 0));
    // R6
    rx_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_pend[RX_SUM_BIT] == (($countones(ep_pend[31:16] & ~ep_msk[31:16])) != 0));
    // R7
    dma_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_pend[DMA_SUM_BIT] == (($countones(dma_pend & ~dma_msk)) != 0));
    // R9
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !irq_out);
    // R9
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !gate);
    // R8
    pol_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && cfg[POL_BIT]) |-> (irq_out == ($countones(top_pend & ~top_msk) != 0)));
    // R8
    pol_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !cfg[POL_BIT]) |-> (irq_out == ($countones(top_pend & ~top_msk) == 0)));
    // R2
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TOP_SET) |=>
        ((top_pend & $past(bus_wdata) & FREE_BITS) == ($past(bus_wdata) & FREE_BITS)));
    // R11
    tmr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |=> top_pend[TMR_BIT]);
endmodule

bind irq_tree_top irq_tree_chk #(.DMA_W(DMA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tmr_expire(tmr_expire),
    .irq_out(irq_out), .gate(gate), .cfg(st_q.cfg),
    .top_pend(top_pend_q), .top_msk(top_msk_q),
    .ep_pend(ep_pend_q), .ep_msk(ep_msk_q),
    .dma_pend(dma_pend_q), .dma_msk(dma_msk_q)
);

// File: tb/sim_irq_tree_top.sv
`timescale 1ns/1ps
module sim_irq_tree_top;
    localparam int DMA_W  = 16;
    localparam int SETTLE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on = 1'b0;
    logic bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ep_evt = '0;
    logic [DMA_W-1:0] dma_evt = '0;
    logic [31:0] top_evt = '0;
    logic tmr_expire = 1'b0;
    logic vbus_edge = 1'b0;
    logic irq_out;

    always #5 clk = ~clk;

    irq_tree_top #(.DMA_W(DMA_W), .SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_evt(ep_evt), .dma_evt(dma_evt), .top_evt(top_evt),
        .tmr_expire(tmr_expire), .vbus_edge(vbus_edge), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_top, m_tmsk, m_ep, m_emsk, m_dma, m_dmsk, m_cfg;
    int m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_top = 0; m_ep = 0; m_dma = 0; m_cfg = 0;
            m_tmsk = '1; m_emsk = '1; m_dmsk = 32'h0000_ffff;
            m_cnt = 0;
        end else begin
            if (!pwr_on) m_cnt = 0;
            else if (m_cnt < SETTLE) m_cnt++;
            if (bus_wr) begin
                case (bus_addr)
                    1: m_top |= bus_wdata;  2: m_top &= ~bus_wdata;  3: m_tmsk = bus_wdata;
                    5: m_ep  |= bus_wdata;  6: m_ep  &= ~bus_wdata;  7: m_emsk = bus_wdata;
                    9: m_dma |= bus_wdata & 32'hffff; 10: m_dma &= ~bus_wdata;
                    11: m_dmsk = bus_wdata & 32'hffff;
                    12: m_cfg = bus_wdata;
                    default: ;
                endcase
            end
            m_ep  |= ep_evt;
            m_dma |= 32'(dma_evt);
            m_top |= top_evt;
            if (tmr_expire) m_top[16] = 1'b1;
            if (vbus_edge)  m_top[15] = 1'b1;
            m_top[9] = 0; m_top[8] = 0; m_top[24] = 0;
            for (int i = 0; i < 32; i++) begin
                if (m_ep[i] && !m_emsk[i]) begin
                    if (i < 16) m_top[9] = 1; else m_top[8] = 1;
                end
                if (m_dma[i] && !m_dmsk[i]) m_top[24] = 1;
            end
        end
    end

    function automatic logic exp_irq();
        bit any = 0;
        for (int i = 0; i < 32; i++) if (m_top[i] && !m_tmsk[i]) any = 1;
        if (m_cnt != SETTLE) return 1'b0;
        return m_cfg[17] ? any : !any;
    endfunction

    function automatic logic [31:0] exp_rd(input int a);
        case (a)
            0, 1, 2: return m_top;   3: return m_tmsk;
            4, 5, 6: return m_ep;    7: return m_emsk;
            8, 9, 10: return m_dma;  11: return m_dmsk;
            12: return m_cfg;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (irq_out !== exp_irq()) begin
                n_bad++;
                $display("FAIL %s irq_out at %0t: actual %0b expected %0b",
                         (m_cnt == SETTLE) ? "R8" : "R9", $time, irq_out, exp_irq());
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        bus_wr = 0; bus_addr = 4'(a);
        #1;
        n_chk++;
        if (bus_rdata !== exp_rd(a)) begin
            n_bad++;
            $display("FAIL %s read addr %0d: actual %08h expected %08h",
                     tag, a, bus_rdata, exp_rd(a));
        end
    endtask

    task automatic pulse(input logic t, input logic v, input logic [31:0] e,
                         input logic [DMA_W-1:0] dm, input logic [31:0] te);
        @(negedge clk);
        tmr_expire = t; vbus_edge = v; ep_evt = e; dma_evt = dm; top_evt = te;
        @(negedge clk);
        tmr_expire = 0; vbus_edge = 0; ep_evt = 0; dma_evt = 0; top_evt = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        for (int a = 0; a < 13; a++) rd(a, "R1");
        // R9 settle window with idle state and clear sense
        pwr_on = 1;
        repeat (SETTLE + 4) @(negedge clk);
        // R8 active-high sense
        wr(12, 32'h0002_0000);
        rd(12, "R8");
        // R2 set while masked
        wr(1, 32'h0000_0005);
        rd(0, "R2"); rd(1, "R2"); rd(2, "R2");
        // R4 unmask
        wr(3, 32'h0000_0000);
        rd(3, "R4");
        // R3 clear
        wr(2, 32'h0000_0001);
        rd(0, "R3");
        wr(2, 32'h0000_0004);
        rd(0, "R3");
        // R5 R6 endpoint halves
        wr(5, 32'h0001_0002);
        rd(4, "R5");
        wr(7, 32'h0000_0000);
        rd(0, "R5"); rd(0, "R6");
        wr(7, 32'h0000_ffff);
        rd(0, "R5");
        wr(1, 32'h0100_0300);
        rd(0, "R5");
        wr(7, 32'h0000_0000);
        wr(2, 32'h0100_0300);
        rd(0, "R5");
        wr(6, 32'hffff_ffff);
        rd(0, "R6");
        // R7 DMA summary
        wr(11, 32'h0000_fff0);
        pulse(0, 0, 0, 16'h0001, 0);
        rd(0, "R7"); rd(8, "R12");
        pulse(0, 0, 0, 16'h0010, 0);
        rd(0, "R7");
        wr(10, 32'h0000_0010);
        rd(0, "R7");
        // R10 hardware events
        pulse(1, 1, 32'h8000_0000, 0, 32'h0000_0040);
        rd(0, "R10"); rd(4, "R10");
        // R11 clear vs timer in same cycle
        wr(2, 32'hffff_ffff);
        @(negedge clk);
        bus_wr = 1; bus_addr = 4'd2; bus_wdata = 32'h0001_0000; tmr_expire = 1;
        @(negedge clk);
        bus_wr = 0; tmr_expire = 0;
        rd(0, "R11");
        // R8 clear sense with pending
        wr(12, 32'h0000_0000);
        repeat (2) @(negedge clk);
        wr(2, 32'hffff_ffff);
        wr(6, 32'hffff_ffff);
        repeat (2) @(negedge clk);
        // R9 power drop and return
        pwr_on = 0;
        repeat (3) @(negedge clk);
        pwr_on = 1;
        repeat (SETTLE + 3) @(negedge clk);
        // R12 unmapped address
        wr(14, 32'hdead_beef);
        rd(14, "R12");
        rd(13, "R12");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule